// File: doc/BRIEF.md
# Bidirectional Parallel Strobe Handshake Controller

This block runs a four-phase, two-wire handshake for a parallel byte port. A mode pin picks the direction. In receive mode a peer drives the byte and an active-low "byte present" strobe, and the block answers on a ready line. In transmit mode the block drives the byte and the strobe, and the peer answers on ready. Only the line that is the block's output in the current mode has its enable raised.

On the core side, received bytes leave through a valid/ready stream. Back-pressure works as follows. While `rd_valid` is high and `rd_ready` is low, the byte and the valid flag hold. The port's ready line also stays low, so the peer cannot push another byte. A byte leaves on any clock edge where both `rd_valid` and `rd_ready` are high. Bytes to send enter through a second valid/ready stream. `wr_ready` is high only in transmit mode with the handshake idle. A byte is taken on the edge where both `wr_valid` and `wr_ready` are high. The plain `busy` flag then stays high until the peer has finished the handshake.

Both incoming handshake lines pass through a synchroniser with `SYNC_STAGES` flops (two by default). Edge detection happens after the synchroniser. With the default depth, a peer edge affects the block's outputs three clock edges after it is first sampled.

Top module: `pport_handshake`

## Requirements
- R1: After reset, `rdy_out`=1, `dav_out_n`=1, `rd_valid`=0 and `busy`=0. `wr_ready` equals `mode_out`.
- R2: In receive mode (`mode_out`=0), a falling edge on `dav_in_n` captures `pad_data_in`. With the default depth, the byte appears on `rd_data` with `rd_valid`=1 three clock edges after the fall is first sampled.
- R3: In receive mode, `rdy_out` falls in the same cycle that `rd_valid` rises, and it stays low while `dav_in_n` is low.
- R4: In receive mode, `rdy_out` rises only once the synchronised `dav_in_n` is high and the byte has been read. If the read came first, it rises three edges after `dav_in_n` rises. If the read comes last, it rises on the read edge.
- R5: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` and `rd_data` hold. A read edge clears `rd_valid`.
- R6: `wr_ready` is high only in transmit mode with the handshake idle. An accepted write raises `busy` on that same edge.
- R7: In transmit mode, the written byte is on `pad_data_out` at least one cycle before `dav_out_n` falls. `dav_out_n` falls only while the synchronised `rdy_in` is high.
- R8: In transmit mode, `dav_out_n` returns high only after the synchronised `rdy_in` has gone low: three edges after `rdy_in` falls.
- R9: `busy` stays high until the synchronised `rdy_in` is high again after `dav_out_n` has risen (three edges after `rdy_in` rises). No new strobe falls before then.
- R10: Direction enables: `pad_data_oe`=`dav_oe`=`mode_out` and `rdy_oe`=!`mode_out`. In receive mode `wr_valid` is ignored: `wr_ready`=0, `busy`=0 and `dav_out_n`=1. In transmit mode `dav_in_n` is ignored: `rd_valid`=0 and `rdy_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_out | input | 1 | 1 = transmit mode, 0 = receive mode |
| pad_data_in | input | 8 | Byte from the port pins |
| pad_data_out | output | 8 | Byte driven to the port pins |
| pad_data_oe | output | 1 | Output enable for the byte pins |
| dav_in_n | input | 1 | Peer's active-low byte-present strobe |
| dav_out_n | output | 1 | Block's active-low byte-present strobe |
| dav_oe | output | 1 | Output enable for the strobe pin |
| rdy_in | input | 1 | Peer's ready line |
| rdy_out | output | 1 | Block's ready line |
| rdy_oe | output | 1 | Output enable for the ready pin |
| wr_valid | input | 1 | Core has a byte to send |
| wr_ready | output | 1 | Block accepts a byte to send |
| wr_data | input | 8 | Byte to send |
| busy | output | 1 | Transmit handshake in progress |
| rd_valid | output | 1 | A received byte is waiting |
| rd_ready | input | 1 | Core takes the received byte |
| rd_data | output | 8 | Received byte |

## Verification
Some properties are checked on every cycle. The received byte holds under back-pressure. The ready line falls only with a waiting byte and rises only with none waiting. An accepted write always raises busy. The strobe falls only after a cycle of stable data, with busy already high. In receive mode the transmit side stays silent. Other behaviour only the bench's scenarios can show, because it depends on exact edge counts through the synchroniser. This covers capture latency, where the ready line rises for each read order, the release of the strobe after ready falls, and the end of busy. It also covers a write that waits on a peer that is not yet ready, the line that is ignored in each mode, and a reset taken in the middle of a transfer.

// File: rtl/pphs_pkg.sv
package pphs_pkg;
  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_SETUP   = 2'd1,
    TX_DRIVE   = 2'd2,
    TX_RELEASE = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_OPEN = 1'b0,
    RX_HELD = 1'b1
  } rx_state_e;
endpackage

// File: rtl/pphs_sync.sv
module pphs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pphs_rx.sv
module pphs_rx
  import pphs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dav_s,
  input  logic [DW-1:0] pad_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rdy
);
  rx_state_e state;
  logic      dav_q;
  logic      dav_fall;

  assign dav_fall = dav_q & ~dav_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_OPEN;
      dav_q    <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      dav_q <= dav_s;
      if (!enable) begin
        state    <= RX_OPEN;
        rd_valid <= 1'b0;
      end else begin
        case (state)
          RX_OPEN: begin
            if (dav_fall) begin
              rd_data  <= pad_data;
              rd_valid <= 1'b1;
              state    <= RX_HELD;
            end
          end
          RX_HELD: begin
            if (rd_valid && rd_ready) rd_valid <= 1'b0;
            if (dav_s && (!rd_valid || rd_ready)) state <= RX_OPEN;
          end
          default: state <= RX_OPEN;
        endcase
      end
    end
  end

  assign rdy = (state == RX_OPEN);
endmodule

// File: rtl/pphs_tx.sv
module pphs_tx
  import pphs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rdy_s,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          busy,
  output logic          dav_n,
  output logic [DW-1:0] data_out
);
  tx_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      data_out <= '0;
    end else if (!enable) begin
      state <= TX_IDLE;
    end else begin
      case (state)
        TX_IDLE: begin
          if (wr_valid) begin
            data_out <= wr_data;
            state    <= TX_SETUP;
          end
        end
        TX_SETUP:   if (rdy_s)  state <= TX_DRIVE;
        TX_DRIVE:   if (!rdy_s) state <= TX_RELEASE;
        TX_RELEASE: if (rdy_s)  state <= TX_IDLE;
        default:    state <= TX_IDLE;
      endcase
    end
  end

  assign wr_ready = enable && (state == TX_IDLE);
  assign busy     = (state != TX_IDLE);
  assign dav_n    = (state != TX_DRIVE);
endmodule

// File: rtl/pport_handshake.sv
module pport_handshake #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_out,
  input  logic [DW-1:0] pad_data_in,
  output logic [DW-1:0] pad_data_out,
  output logic          pad_data_oe,
  input  logic          dav_in_n,
  output logic          dav_out_n,
  output logic          dav_oe,
  input  logic          rdy_in,
  output logic          rdy_out,
  output logic          rdy_oe,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;
  logic              rx_rdy;
  logic              tx_dav_n;

  assign line_raw = {rdy_in, dav_in_n};

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_sync
      pphs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_raw[i]),
        .q     (line_s[i])
      );
    end
  endgenerate

  pphs_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (!mode_out),
    .dav_s    (line_s[0]),
    .pad_data (pad_data_in),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rdy      (rx_rdy)
  );

  pphs_tx #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (mode_out),
    .rdy_s    (line_s[1]),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .busy     (busy),
    .dav_n    (tx_dav_n),
    .data_out (pad_data_out)
  );

  assign dav_out_n   = tx_dav_n | ~mode_out;
  assign rdy_out     = rx_rdy | mode_out;
  assign pad_data_oe = mode_out;
  assign dav_oe      = mode_out;
  assign rdy_oe      = ~mode_out;
endmodule

// File: rtl/pphs_chk.sv
module pphs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_out,
  input logic [DW-1:0] pad_data_out,
  input logic          pad_data_oe,
  input logic          dav_out_n,
  input logic          rdy_out,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          busy,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data
);
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !mode_out |=> rd_valid && $stable(rd_data));

  // R3
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_out) |-> rd_valid);

  // R4
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_out) |-> !rd_valid);

  // R6
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> busy);

  // R7
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_out_n) |-> $past(busy) && $stable(pad_data_out));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && mode_out |-> dav_out_n);

  // R10
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_out |-> dav_out_n && !pad_data_oe && !wr_ready);
endmodule

bind pport_handshake pphs_chk #(.DW(DW)) u_chk (.*);

// File: tb/pport_handshake_tb.sv
module pport_handshake_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_out = 1'b0;
  logic [DW-1:0] pad_data_in = '0;
  logic [DW-1:0] pad_data_out;
  logic          pad_data_oe;
  logic          dav_in_n = 1'b1;
  logic          dav_out_n;
  logic          dav_oe;
  logic          rdy_in = 1'b1;
  logic          rdy_out;
  logic          rdy_oe;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          busy;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errs   = 0;

  always #2.5 clk = ~clk;

  pport_handshake #(.DW(DW)) u_dut (.*);

  // {transmit, read_before_release, byte}
  localparam logic [9:0] VEC [8] = '{
    10'h2A5, 10'h05A, 10'h1FF, 10'h300,
    10'h03C, 10'h2C3, 10'h181, 10'h27E
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    step(1);
    mode_out = m;
    step(3);
  endtask

  task automatic tx_xfer(input logic [DW-1:0] d);
    step(1);
    wr_valid = 1'b1; wr_data = d;
    chk("R6 wr_ready idle", wr_ready, 1);
    step(1);
    wr_valid = 1'b0;
    chk("R6 busy after write", busy, 1);
    chk("R7 strobe high in setup", dav_out_n, 1);
    chk("R7 data before strobe", pad_data_out, d);
    step(1);
    chk("R7 strobe low", dav_out_n, 0);
    rdy_in = 1'b0;
    step(2);
    chk("R8 strobe held until ready low", dav_out_n, 0);
    step(1);
    chk("R8 strobe released", dav_out_n, 1);
    rdy_in = 1'b1;
    step(2);
    chk("R9 busy until ready high", busy, 1);
    step(1);
    chk("R9 busy cleared", busy, 0);
    chk("R9 no new strobe", dav_out_n, 1);
  endtask

  task automatic rx_xfer(input logic [DW-1:0] d, input logic early);
    step(1);
    pad_data_in = d; dav_in_n = 1'b0;
    step(2);
    chk("R2 not yet captured", rd_valid, 0);
    chk("R3 ready before capture", rdy_out, 1);
    step(1);
    chk("R2 captured valid", rd_valid, 1);
    chk("R2 captured byte", rd_data, d);
    chk("R3 ready low with byte", rdy_out, 0);
    pad_data_in = ~d;
    if (early) begin
      rd_ready = 1'b1;
      step(1);
      rd_ready = 1'b0;
      chk("R5 read clears valid", rd_valid, 0);
      chk("R3 ready low while strobe low", rdy_out, 0);
      dav_in_n = 1'b1;
      step(2);
      chk("R4 ready waits strobe sync", rdy_out, 0);
      step(1);
      chk("R4 ready after strobe high", rdy_out, 1);
    end else begin
      dav_in_n = 1'b1;
      step(4);
      chk("R4 ready waits for read", rdy_out, 0);
      chk("R5 valid held", rd_valid, 1);
      chk("R5 data held", rd_data, d);
      rd_ready = 1'b1;
      step(1);
      rd_ready = 1'b0;
      chk("R5 read clears valid", rd_valid, 0);
      chk("R4 ready on read", rdy_out, 1);
    end
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 rdy_out", rdy_out, 1);
    chk("R1 dav_out_n", dav_out_n, 1);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wr_ready in receive", wr_ready, 0);
    rst_n = 1'b1;
    step(2);

    for (int i = 0; i < 8; i++) begin
      set_mode(VEC[i][9]);
      if (VEC[i][9]) tx_xfer(VEC[i][7:0]);
      else           rx_xfer(VEC[i][7:0], VEC[i][8]);
    end

    // R10 receive mode ignores write side
    set_mode(1'b0);
    chk("R10 data oe", pad_data_oe, 0);
    chk("R10 dav oe", dav_oe, 0);
    chk("R10 rdy oe", rdy_oe, 1);
    wr_valid = 1'b1; wr_data = 8'h99;
    step(6);
    chk("R10 wr_ready low", wr_ready, 0);
    chk("R10 busy low", busy, 0);
    chk("R10 strobe idle", dav_out_n, 1);
    wr_valid = 1'b0;

    // R10 transmit mode ignores peer strobe
    set_mode(1'b1);
    chk("R10 data oe tx", pad_data_oe, 1);
    chk("R10 rdy oe tx", rdy_oe, 0);
    dav_in_n = 1'b0;
    step(6);
    chk("R10 rd_valid stays low", rd_valid, 0);
    chk("R10 rdy_out high", rdy_out, 1);
    dav_in_n = 1'b1;
    step(4);

    // R7 write while peer not ready
    rdy_in = 1'b0;
    step(3);
    wr_valid = 1'b1; wr_data = 8'h4D;
    step(1);
    wr_valid = 1'b0;
    step(4);
    chk("R7 strobe waits for ready", dav_out_n, 1);
    chk("R7 busy while waiting", busy, 1);
    rdy_in = 1'b1;
    step(2);
    chk("R7 strobe still high", dav_out_n, 1);
    step(1);
    chk("R7 strobe low after ready", dav_out_n, 0);
    chk("R7 data on pins", pad_data_out, 8'h4D);
    rdy_in = 1'b0;
    step(3);
    rdy_in = 1'b1;
    step(3);
    chk("R9 busy cleared", busy, 0);

    // R1 reset mid transfer
    wr_valid = 1'b1; wr_data = 8'h11;
    step(1);
    wr_valid = 1'b0;
    step(1);
    chk("R7 strobe low before reset", dav_out_n, 0);
    rst_n = 1'b0;
    step(1);
    chk("R1 strobe after reset", dav_out_n, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R1 wr_ready tx after reset", wr_ready, 1);
    rst_n = 1'b1;
    step(3);

    summary();
    $finish;
  end
endmodule